// File: doc/BRIEF.md
# Two-Point Signature Resistance Evaluator

This block decides whether the load on a Power over Ethernet port shows a valid powered-device signature. After a start request it switches on a first test current and waits a set number of settle cycles. It then samples the port voltage from an ADC. It repeats the same steps with a second, larger test current. The resistance is taken as the slope between the two operating points, ΔV/ΔI. Using the slope cancels any constant voltage offset, such as series diodes, and any constant leakage current.

No divider is built. The slope is tested by comparing the scaled voltage difference against each threshold times the fixed current difference. Voltages are unsigned codes with a 1 mV step, so 10 V is code 10000. Currents are codes with a 1 µA step. Thresholds are resistance codes with one fractional bit, in kΩ: 34 stands for 17 kΩ and 59 stands for 29.5 kΩ. When the sequence ends, the block raises a one-cycle done pulse together with a 2-bit result code.

Top module: `sig_res_eval`

## Requirements
- R1: While reset is held and after it is released, done and src_en are 0 and result is 2'b00.
- R2: When start is high in an idle cycle, src_en is high from the next cycle until the second sample is taken. src_step is 0 for the first SETTLE_CYC+2 of those cycles and 1 for the remaining SETTLE_CYC+2. Both are 0 outside the sequence.
- R3: done goes high exactly 2*SETTLE_CYC+6 clock edges after the edge that accepts start.
- R4: done is high for exactly one cycle. result changes only in a done cycle and holds its value until the next done.
- R5: With ΔV = V2 − V1 and ΔI = I2_CODE − I1_CODE, if 34·ΔI ≤ 2·ΔV ≤ 59·ΔI (inclusive), result is 2'b00 (valid). Boundary example with ΔI = 100: ΔV = 1700 and ΔV = 2950 are both valid.
- R6: If 2·ΔV < 34·ΔI, result is 2'b01 (too low). This includes a negative ΔV and a load of about 150 Ω.
- R7: If 2·ΔV > 59·ΔI, result is 2'b10 (too high).
- R8: If either voltage sample is at or above code 10000, result is 2'b11 (voltage out of range), whatever ΔV is.
- R9: A common offset added to both samples does not change the result, as long as neither sample reaches code 10000.
- R10: A start pulse that arrives while a sequence is running, including the done cycle, is ignored. It neither restarts nor lengthens the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a measurement; accepted only when idle |
| adc_code | input | VW | Port voltage sample, 1 mV per code |
| src_en | output | 1 | Enable for the test current source |
| src_step | output | 1 | Current select: 0 = first current, 1 = second current |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 valid, 01 too low, 10 too high, 11 voltage out of range |

## Verification
The assertions assume that start is only meaningful in idle cycles. They also assume that adc_code carries the voltage belonging to the current selected by src_en and src_step by the time the sample cycle ends. The bench models the port as a voltage source that follows the current-select outputs. It drives garbage (all ones) whenever the source is off, so any sample taken too early shows up as an error. Sample pairs sweep offsets and slopes across both threshold edges, the 10 V limit and negative slopes. Start is re-pulsed in the middle of some runs.

// File: rtl/sre_pkg.sv
// Package: shared state and result encodings for the signature evaluator.
// Assumes: result encoding is fixed by the port contract (00/01/10/11).
package sre_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_FORCE1, ST_SET1, ST_SAMP1,
        ST_FORCE2, ST_SET2, ST_SAMP2, ST_EVAL, ST_DONE
    } sre_state_t;

    typedef enum logic [1:0] {
        RES_VALID = 2'b00,
        RES_LOW   = 2'b01,
        RES_HIGH  = 2'b10,
        RES_OOR   = 2'b11
    } sre_res_t;
endpackage

// File: rtl/sre_seq.sv
// Module: sre_seq - measurement sequencer.
// Steps: force I1, settle, sample V1, force I2, settle, sample V2, evaluate, done.
// Assumes: SETTLE_CYC >= 1; start is looked at only in the idle state.
module sre_seq
    import sre_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic src_en,
    output logic src_step,
    output logic cap1,
    output logic cap2,
    output logic eval_en,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    sre_state_t st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic settled;

    assign settled = (cnt_q == CNT_LAST);

    // Next-state selection for the measurement sequence
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_FORCE1;
            ST_FORCE1: st_d = ST_SET1;
            ST_SET1:   if (settled) st_d = ST_SAMP1;
            ST_SAMP1:  st_d = ST_FORCE2;
            ST_FORCE2: st_d = ST_SET2;
            ST_SET2:   if (settled) st_d = ST_SAMP2;
            ST_SAMP2:  st_d = ST_EVAL;
            ST_EVAL:   st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Settle counter: runs in settle states, cleared elsewhere
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if ((st_q == ST_SET1 || st_q == ST_SET2) && !settled)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    assign src_en   = (st_q inside {ST_FORCE1, ST_SET1, ST_SAMP1,
                                    ST_FORCE2, ST_SET2, ST_SAMP2});
    assign src_step = (st_q inside {ST_FORCE2, ST_SET2, ST_SAMP2});
    assign cap1     = (st_q == ST_SAMP1);
    assign cap2     = (st_q == ST_SAMP2);
    assign eval_en  = (st_q == ST_EVAL);
    assign done     = (st_q == ST_DONE);
endmodule

// File: rtl/sre_eval.sv
// Module: sre_eval - combinational slope classifier without division.
// Compares (V2-V1) << FRAC against R_LO_Q*dI and R_HI_Q*dI.
// Assumes: I2_CODE > I1_CODE, VW + FRAC < 30, thresholds fit in 32 bits.
module sre_eval
    import sre_pkg::*;
#(
    parameter int VW      = 14,
    parameter int VLIM    = 10000,
    parameter int I1_CODE = 170,
    parameter int I2_CODE = 270,
    parameter int FRAC    = 1,
    parameter int R_LO_Q  = 34,
    parameter int R_HI_Q  = 59
) (
    input  logic [VW-1:0] v1,
    input  logic [VW-1:0] v2,
    output sre_res_t      code
);
    localparam int DI = I2_CODE - I1_CODE;
    localparam logic signed [31:0] LO_LIM = 32'(R_LO_Q * DI);
    localparam logic signed [31:0] HI_LIM = 32'(R_HI_Q * DI);
    localparam logic [VW-1:0] VLIM_C = VW'(VLIM);

    logic signed [VW:0]  dv;
    logic signed [31:0]  dv_s;

    // Slope numerator with offsets cancelled, scaled to the threshold grid
    always_comb begin
        dv   = $signed({1'b0, v2}) - $signed({1'b0, v1});
        dv_s = $signed({{(31 - VW){dv[VW]}}, dv}) <<< FRAC;
    end

    // Window decision; an out-of-range voltage has priority
    always_comb begin
        if (v1 >= VLIM_C || v2 >= VLIM_C) code = RES_OOR;
        else if (dv_s < LO_LIM)           code = RES_LOW;
        else if (dv_s > HI_LIM)           code = RES_HIGH;
        else                              code = RES_VALID;
    end
endmodule

// File: rtl/sig_res_eval.sv
// Module: sig_res_eval - top of the two-point signature resistance evaluator.
// Captures one ADC sample per current step, classifies the slope and holds the code.
// Assumes: adc_code is settled to the active step by the end of each sample cycle.
module sig_res_eval
    import sre_pkg::*;
#(
    parameter int VW         = 14,
    parameter int VLIM       = 10000,
    parameter int I1_CODE    = 170,
    parameter int I2_CODE    = 270,
    parameter int FRAC       = 1,
    parameter int R_LO_Q     = 34,
    parameter int R_HI_Q     = 59,
    parameter int SETTLE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] adc_code,
    output logic          src_en,
    output logic          src_step,
    output logic          done,
    output logic [1:0]    result
);
    logic cap1, cap2, eval_en;
    logic [VW-1:0] v1_q, v2_q;
    sre_res_t code_c, res_q;

    sre_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_en(src_en), .src_step(src_step),
        .cap1(cap1), .cap2(cap2), .eval_en(eval_en), .done(done)
    );

    sre_eval #(
        .VW(VW), .VLIM(VLIM), .I1_CODE(I1_CODE), .I2_CODE(I2_CODE),
        .FRAC(FRAC), .R_LO_Q(R_LO_Q), .R_HI_Q(R_HI_Q)
    ) u_eval (
        .v1(v1_q), .v2(v2_q), .code(code_c)
    );

    // Sample capture for both current steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= '0;
            v2_q <= '0;
        end else begin
            if (cap1) v1_q <= adc_code;
            if (cap2) v2_q <= adc_code;
        end
    end

    // Result register: loaded at evaluation, held until the next one
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= RES_VALID;
        else if (eval_en) res_q <= code_c;
    end

    assign result = res_q;
endmodule

// File: rtl/sre_checker.sv
// Module: sre_checker - protocol and decision properties, bound to sig_res_eval.
// Assumes: observes the top ports and the two captured samples.
module sre_checker #(
    parameter int VW   = 14,
    parameter int VLIM = 10000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          src_en,
    input logic          src_step,
    input logic          done,
    input logic [1:0]    result,
    input logic [VW-1:0] v1_q,
    input logic [VW-1:0] v2_q
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R4
    AST_STEP_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        src_step |-> src_en); // R2
    AST_SRC_OFF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !src_en); // R2
    AST_SEQ_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_en) |-> $past(start)); // R2
    AST_OOR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (v1_q >= VW'(VLIM) || v2_q >= VW'(VLIM))) |-> result == 2'b11); // R8
endmodule

bind sig_res_eval sre_checker #(.VW(VW), .VLIM(VLIM)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .src_en(src_en),
    .src_step(src_step), .done(done), .result(result),
    .v1_q(v1_q), .v2_q(v2_q)
);

// File: tb/sig_res_eval_test.sv
module sig_res_eval_test;
    localparam int VW = 14;
    localparam int S  = 4;
    localparam int DI = 100;
    localparam int LAT = 2 * S + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VW-1:0] adc_code;
    logic src_en, src_step, done;
    logic [1:0] result;

    int checks = 0;
    int failures = 0;
    int va = 0;
    int vb = 0;

    always #2 clk = ~clk;

    sig_res_eval #(
        .VW(VW), .VLIM(10000), .I1_CODE(170), .I2_CODE(270),
        .FRAC(1), .R_LO_Q(34), .R_HI_Q(59), .SETTLE_CYC(S)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_code(adc_code),
        .src_en(src_en), .src_step(src_step), .done(done), .result(result)
    );

    // Port model: voltage follows the selected current, garbage when off
    always @(negedge clk)
        adc_code <= !src_en ? '1 : (src_step ? VW'(vb) : VW'(va));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int a, input int b);
        int d;
        if (a >= 10000 || b >= 10000) return 3;
        d = b - a;
        if (2 * d < 34 * DI) return 1;
        if (2 * d > 59 * DI) return 2;
        return 0;
    endfunction

    // One measurement; poke re-pulses start mid-run (R10)
    task automatic run(input int a, input int b, input bit poke, input string req);
        int n;
        bit seq_ok;
        int e;
        e = exp_code(a, b);
        va = a;
        vb = b;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        seq_ok = 1'b1;
        while (!done && n < 60) begin
            if (src_en !== (n <= 4 + 2 * S)) seq_ok = 1'b0;
            if (src_step !== (n >= 3 + S && n <= 4 + 2 * S)) seq_ok = 1'b0;
            start = (poke && (n == 3 || n == LAT - 2)) ? 1'b1 : 1'b0;
            @(negedge clk);
            n++;
        end
        start = (poke) ? 1'b1 : 1'b0;
        chk(seq_ok, "R2 source sequence", int'(seq_ok), 1);
        chk(n == LAT, poke ? "R10 latency with busy start" : "R3 latency", n, LAT);
        chk(int'(result) == e, req, int'(result), e);
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R4 done single cycle", int'(done), 0);
        chk(int'(result) == e, "R4 result held", int'(result), e);
        if (poke) chk(!src_en, "R10 no restart", int'(src_en), 0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int offs[4];
        offs = '{0, 250, 900, 3000};
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        chk(src_en == 1'b0, "R1 src_en in reset", int'(src_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && src_en == 1'b0, "R1 idle after reset", int'(src_en), 0);
        chk(result == 2'b00, "R1 result after reset", int'(result), 0);

        // R5 R6 R7 boundaries at the window edges
        run(1000, 2700, 1'b0, "R5 low edge valid");
        run(1000, 2699, 1'b0, "R6 just below low edge");
        run(1000, 3950, 1'b0, "R5 high edge valid");
        run(1000, 3951, 1'b0, "R7 just above high edge");
        run(500, 515, 1'b0, "R6 legacy 150 ohm");
        run(3000, 2800, 1'b0, "R6 negative slope");
        run(2000, 2000, 1'b0, "R6 zero slope");
        // R8 out of range on either sample, with priority
        run(9999, 9999, 1'b0, "R6 below limit");
        run(10000, 12500, 1'b0, "R8 first sample at limit");
        run(7000, 10000, 1'b0, "R8 second sample at limit");
        run(7400, 9999, 1'b0, "R5 second sample just below limit");
        run(16383, 16383, 1'b0, "R8 full scale");
        // R9 same slope, different offsets
        run(0, 2500, 1'b0, "R9 offset 0");
        run(4000, 6500, 1'b0, "R9 offset 4000");
        // R10 start pulses while busy
        run(1200, 3800, 1'b1, "R10 result valid");
        run(100, 3600, 1'b1, "R10 result high");

        // R5 R6 R7 R9 sweep of slopes over several offsets
        foreach (offs[k]) begin
            for (int dv = -50; dv <= 4200; dv += 31) begin
                if (offs[k] + dv >= 0)
                    run(offs[k], offs[k] + dv, 1'b0, "R9 sweep");
            end
        end
        // R8 sweep around the voltage limit
        for (int v = 9990; v <= 10010; v++) begin
            run(v, 5000, 1'b0, "R8 sweep first");
            run(7000, v, 1'b0, "R8 sweep second");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule